// File: doc/BRIEF.md
# Reference Clock Period Meter

The block measures how long one period of an external reference clock lasts, expressed as a count of local bus clock cycles. The reference signal is asynchronous to the local clock. It passes through a two-flop synchronizer, and a rising-edge detector follows the synchronizer. A free-running counter measures the gap between consecutive detected edges. The block needs no software to start it: every new reference edge refreshes the latest result.

Software takes a snapshot of the latest result by writing to a latch register. Write data is ignored. The snapshot sits in a holding register, and software reads it as two byte-wide registers. The snapshot stays fixed until the next latch write, so reading the two bytes one after the other always gives one coherent 16-bit value. The counter saturates at all-ones instead of wrapping. A reference that has stopped, or a period too long to fit in 16 bits, therefore reads as 0xFFFF.

Top module: `clk_period_meter`

## Requirements
- R1: With a periodic reference whose period is P local cycles (2 <= P < 65535), a snapshot taken after at least three reference periods reads exactly P.
- R2: Measurement repeats on every reference rising edge without any bus access. When the reference period changes, a later snapshot reflects the new period with no other action.
- R3: A write with `addr_i` = 0x61 copies the latest result into the holding register. Writes to any other address leave it unchanged, and it does not follow new measurements between latch writes.
- R4: With `rd_i` high, address 0x63 returns holding bits 15:8 and address 0x62 returns bits 7:0. Writes to these addresses have no effect. Any other address, or `rd_i` low, returns 0x00.
- R5: If the reference stays static for 65535 or more local cycles, the next snapshot reads 0xFFFF.
- R6: The counter stops at 0xFFFF and does not wrap. The first edge after saturation, or the first edge after reset, yields 0xFFFF. The following edge yields a valid period.
- R7: After reset, both byte registers read 0xFF.
- R8: Reads do not change the holding register. Repeated reads of both bytes return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Asynchronous reference clock to be measured |
| addr_i | input | 8 | Register offset |
| rd_i | input | 1 | Read strobe; `rdata_o` is valid in the same cycle |
| wr_i | input | 1 | Write strobe (a write to the latch offset captures the result) |
| rdata_o | output | 8 | Read data |

## Verification
The bench sweeps the reference period over small values (2, 3, 4, 5, 7, 8, 13), values at byte boundaries (255, 256, 257), and larger values. Every expected reading equals the generated period. This separates an off-by-one in the counter restart from a byte-lane swap or a missing carry into the high byte. A static reference held past 65535 cycles separates saturation from wrap-around. A single edge followed by further periods checks that the first count after saturation is discarded and the next one is valid. A measurement changed between latch writes, together with writes to non-latch offsets, shows that the holding register moves only on the latch write.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned ADDR_W_DEF  = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic [7:0]  ADDR_BASE_DEF  = 8'h62;  // low byte; higher bytes follow upward
  localparam logic [7:0]  ADDR_LATCH_DEF = 8'h61;
endpackage

// File: rtl/cpm_edge_sync.sv
module cpm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe <= '0;
    else         pipe <= {pipe[STAGES-1:0], async_i};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/cpm_period_cnt.sv
module cpm_period_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] latest_o
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic sat;
  assign sat = (cnt_o == MAX);

  // counter starts saturated so the partial period before the first edge is discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= MAX;
      latest_o <= MAX;
    end else if (rise_i) begin
      latest_o <= cnt_o;
      cnt_o    <= ONE;
    end else if (!sat) begin
      cnt_o    <= cnt_o + ONE;
    end else begin
      latest_o <= MAX;
    end
  end
endmodule

// File: rtl/cpm_byte_regs.sv
module cpm_byte_regs #(
  parameter int unsigned W          = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  ADDR_BASE  = 8'h62,
  parameter logic [7:0]  ADDR_LATCH = 8'h61
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [W-1:0]      latest_i,
  output logic [W-1:0]      hold_o,
  output logic [7:0]        rdata_o
);
  localparam int unsigned NB = W / 8;

  logic latch_hit;
  assign latch_hit = wr_i && (addr_i == ADDR_W'(ADDR_LATCH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_o <= '1;
    else if (latch_hit) hold_o <= latest_i;
  end

  logic [NB-1:0][7:0] lane;
  logic [NB-1:0]      hit;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane[k] = hold_o[8*k +: 8];
    assign hit[k]  = rd_i && (addr_i == ADDR_W'(ADDR_BASE + 8'(k)));
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int k = 0; k < NB; k++) begin
      if (hit[k]) rdata_o = lane[k];
    end
  end
endmodule

// File: rtl/clk_period_meter.sv
module clk_period_meter
  import cpm_pkg::*;
#(
  parameter int unsigned CNT_W      = CNT_W_DEF,
  parameter int unsigned ADDR_W     = ADDR_W_DEF,
  parameter logic [7:0]  ADDR_BASE  = ADDR_BASE_DEF,
  parameter logic [7:0]  ADDR_LATCH = ADDR_LATCH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [7:0]        rdata_o
);
  logic             rise;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] latest;
  logic [CNT_W-1:0] hold;

  cpm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ref_clk_i),
    .rise_o  (rise)
  );

  cpm_period_cnt #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .cnt_o    (cnt),
    .latest_o (latest)
  );

  cpm_byte_regs #(
    .W          (CNT_W),
    .ADDR_W     (ADDR_W),
    .ADDR_BASE  (ADDR_BASE),
    .ADDR_LATCH (ADDR_LATCH)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .latest_i (latest),
    .hold_o   (hold),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int unsigned W          = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  ADDR_BASE  = 8'h62,
  parameter logic [7:0]  ADDR_LATCH = 8'h61
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rise_i,
  input logic [W-1:0]      cnt_i,
  input logic [W-1:0]      latest_i,
  input logic [W-1:0]      hold_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [7:0]        rdata_i
);
  localparam logic [W-1:0] MAX = '1;

  logic latch_wr;
  assign latch_wr = wr_i && (addr_i == ADDR_W'(ADDR_LATCH));

  p_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> cnt_i == W'(1));

  p_count_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && cnt_i != MAX) |=> cnt_i == $past(cnt_i) + W'(1));

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_wr |=> hold_i == $past(latest_i));

  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_wr |=> $stable(hold_i));

  p_read_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(ADDR_BASE)) |-> rdata_i == hold_i[7:0]);

  p_read_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(ADDR_BASE + 8'(W/8 - 1))) |-> rdata_i == hold_i[W-1:W-8]);

  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_i == 8'h00);

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == MAX && !rise_i) |=> cnt_i == MAX);

  p_sat_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == MAX) |=> latest_i == MAX);
endmodule

bind clk_period_meter cpm_checker #(
  .W          (CNT_W),
  .ADDR_W     (ADDR_W),
  .ADDR_BASE  (ADDR_BASE),
  .ADDR_LATCH (ADDR_LATCH)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rise_i   (rise),
  .cnt_i    (cnt),
  .latest_i (latest),
  .hold_i   (hold),
  .addr_i   (addr_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .rdata_i  (rdata_o)
);

// File: tb/clk_period_meter_tb.sv
`timescale 1ns/1ps
module clk_period_meter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clk_period_meter u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_clk_i (ref_clk),
    .addr_i    (addr),
    .rd_i      (rd),
    .wr_i      (wr),
    .rdata_o   (rdata)
  );

  task automatic run_ref(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_clk = 1'b1;
      repeat (p/2 - 1) @(negedge clk);
      @(negedge clk) ref_clk = 1'b0;
      repeat (p - p/2 - 1) @(negedge clk);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a);
    @(negedge clk);
    addr = a; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 8'h00;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0; addr = 8'h00;
  endtask

  task automatic check16(input string req, input logic [15:0] exp);
    logic [7:0] hi, lo;
    bus_rd(8'h63, hi);
    bus_rd(8'h62, lo);
    checks++;
    if ({hi, lo} !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, {hi, lo}, exp);
    end
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int plist[13] = '{2, 3, 4, 5, 7, 8, 13, 100, 255, 256, 257, 1000, 4095};
    logic [7:0] d;
    logic [7:0] d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7: reset value of both bytes
    bus_rd(8'h63, d);  check8("R7 hi reset", d, 8'hFF);
    bus_rd(8'h62, d);  check8("R7 lo reset", d, 8'hFF);

    // R4: idle and unmapped reads
    @(negedge clk); addr = 8'h63; #1 check8("R4 no rd", rdata, 8'h00);
    bus_rd(8'h64, d);  check8("R4 unmapped", d, 8'h00);

    // R6: first edge after reset is discarded
    run_ref(10, 1);
    bus_wr(8'h61);
    check16("R6 first edge after reset", 16'hFFFF);

    // R1: period sweep
    foreach (plist[i]) begin
      run_ref(plist[i], 4);
      bus_wr(8'h61);
      check16("R1 period sweep", 16'(plist[i]));
    end

    // R3, R2: holding frozen until latch; measurement keeps running
    run_ref(20, 4);
    bus_wr(8'h61);
    check16("R3 latch 20", 16'd20);
    run_ref(30, 4);
    check16("R3 no latch", 16'd20);
    bus_wr(8'h60);
    bus_wr(8'h63);
    bus_wr(8'h62);
    check16("R4 read-only/R3 other addr", 16'd20);
    bus_wr(8'h61);
    check16("R2 new period tracked", 16'd30);

    // R8: repeated reads stay the same
    bus_rd(8'h63, d); bus_rd(8'h63, d2); check8("R8 hi repeat", d2, d);
    bus_rd(8'h62, d); bus_rd(8'h62, d2); check8("R8 lo repeat", d2, d);
    check16("R8 value intact", 16'd30);

    // R5: static reference saturates
    @(negedge clk) ref_clk = 1'b0;
    repeat (66000) @(negedge clk);
    bus_wr(8'h61);
    check16("R5 static ref", 16'hFFFF);

    // R6: first edge after saturation invalid, following one valid
    run_ref(10, 1);
    bus_wr(8'h61);
    check16("R6 edge after sat", 16'hFFFF);
    run_ref(10, 3);
    bus_wr(8'h61);
    check16("R6 recovery", 16'd10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule